// File: doc/BRIEF.md
# Digit-serial GF(3^m) polynomial-basis multiplier

This block multiplies two elements of the ternary extension field GF(3^m). Each element is a polynomial of degree below m with coefficients in GF(3), and each coefficient takes two bits of a 2m-bit bus. The product is reduced modulo a fixed trinomial x^m + c1·x^k + c0. The position k and the constants c1 and c0 are parameters, and the defaults describe x^97 + x^16 + 2.

The second operand is consumed D coefficients per clock, starting from its most significant group. In each cycle the running accumulator is multiplied by x^D and reduced. The D partial products of the first operand, each already shifted and reduced, are then added to it. A start pulse launches an operation. After ceil(m/D) cycles a single-cycle done pulse marks a reduced result, and that result stays on the output until the next accepted start.

With D=1 the block becomes a coefficient-serial multiplier. Larger values of D, such as 4, 8 or 12, trade adder and shifter width for fewer cycles. When m is not a multiple of D, the top group of the second operand is filled with zero digits.

Top module: `gf3m_digit_mul`

## Requirements
- R1: Digit i of every operand and of the result occupies bits [2i+1:2i] and is encoded as 00=0, 01=1, 10=2; the result never contains the code 11.
- R2: When done is high, the result equals a·b reduced modulo x^M + TRI_MID·x^TRI_K + TRI_CONST, with all coefficient arithmetic done modulo 3.
- R3: done rises exactly ceil(M/D) clock edges after the edge that accepts start.
- R4: done is high for exactly one cycle per accepted operation.
- R5: A start pulse that arrives while an operation is in progress is ignored: it changes neither that operation's result nor its timing.
- R6: The result stays unchanged from the done cycle until the next accepted start.
- R7: When M is not a multiple of D, the top digit group of b is zero-padded and the product is still exact.
- R8: With D=1 the block works coefficient-serially and takes M cycles per product.
- R9: While reset is asserted and directly after it, done is low and the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches a product when the block is idle |
| a_i | input | 2*M | Multiplicand, sampled on the accepting edge |
| b_i | input | 2*M | Multiplier, sampled on the accepting edge and scanned D digits per cycle |
| done_o | output | 1 | Single-cycle pulse that marks a valid result |
| res_o | output | 2*M | Reduced product |

## Verification
A fault in the shift-and-reduce chain or in a partial-product term corrupts the result in that same operation. Such a fault shows as a wrong digit on res_o in the done cycle, ceil(M/D) cycles after start. A misloaded group counter shows as a done pulse that comes early or late, or as a result built from the wrong digit group. A busy flag that drops or re-arms wrongly shows as either a second done pulse or a result that absorbed a start pulse given in mid-operation. The bench therefore compares every product against a schoolbook model with long division. It measures the latency and width of each done pulse, and it checks that res_o still holds its value many cycles later.

// File: rtl/gf3_pkg.sv
package gf3_pkg;
  typedef logic [1:0] trit_t;

  function automatic trit_t t_add(trit_t a, trit_t b);
    logic [2:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s >= 3'd3) ? trit_t'(s - 3'd3) : s[1:0];
  endfunction

  function automatic trit_t t_neg(trit_t a);
    return (a == 2'd1) ? 2'd2 : (a == 2'd2) ? 2'd1 : 2'd0;
  endfunction

  function automatic trit_t t_mul(trit_t a, trit_t b);
    if (a == 2'd0 || b == 2'd0) return 2'd0;
    return (a == b) ? 2'd1 : 2'd2;
  endfunction
endpackage

// File: rtl/gf3m_mulx.sv
// y = a * x mod (x^M + MID x^K + CST)
module gf3m_mulx import gf3_pkg::*; #(
  parameter int M   = 97,
  parameter int K   = 16,
  parameter int MID = 1,
  parameter int CST = 2
) (
  input  logic [2*M-1:0] a_i,
  output logic [2*M-1:0] y_o
);
  trit_t top;
  assign top = a_i[2*M-1 -: 2];

  for (genvar i = 0; i < M; i++) begin : g_dig
    if (i == 0) begin : g_lo
      assign y_o[1:0] = t_neg(t_mul(top, trit_t'(CST)));
    end else if (i == K) begin : g_mid
      assign y_o[2*i +: 2] = t_add(a_i[2*(i-1) +: 2], t_neg(t_mul(top, trit_t'(MID))));
    end else begin : g_sh
      assign y_o[2*i +: 2] = a_i[2*(i-1) +: 2];
    end
  end
endmodule

// File: rtl/gf3m_step.sv
// acc_o = acc_i * x^D + sum_j b_j * a * x^j   (all mod f)
module gf3m_step import gf3_pkg::*; #(
  parameter int M   = 97,
  parameter int D   = 4,
  parameter int K   = 16,
  parameter int MID = 1,
  parameter int CST = 2
) (
  input  logic [2*M-1:0] acc_i,
  input  logic [2*M-1:0] a_i,
  input  logic [2*D-1:0] bgrp_i,
  output logic [2*M-1:0] acc_o
);
  logic [2*M-1:0] acc_pw [D+1];
  logic [2*M-1:0] a_pw   [D];
  logic [2*M-1:0] term   [D];
  logic [2*M-1:0] sum    [D+1];

  assign acc_pw[0] = acc_i;
  assign a_pw[0]   = a_i;

  for (genvar j = 0; j < D; j++) begin : g_shift
    gf3m_mulx #(.M(M), .K(K), .MID(MID), .CST(CST)) u_acc_x (
      .a_i(acc_pw[j]), .y_o(acc_pw[j+1])
    );
    if (j < D - 1) begin : g_apw
      gf3m_mulx #(.M(M), .K(K), .MID(MID), .CST(CST)) u_a_x (
        .a_i(a_pw[j]), .y_o(a_pw[j+1])
      );
    end
  end

  assign sum[0] = acc_pw[D];

  for (genvar j = 0; j < D; j++) begin : g_term
    for (genvar i = 0; i < M; i++) begin : g_dig
      assign term[j][2*i +: 2]  = t_mul(a_pw[j][2*i +: 2], bgrp_i[2*j +: 2]);
      assign sum[j+1][2*i +: 2] = t_add(sum[j][2*i +: 2], term[j][2*i +: 2]);
    end
  end

  assign acc_o = sum[D];
endmodule

// File: rtl/gf3m_seq_ctrl.sv
module gf3m_seq_ctrl #(
  parameter int NG = 25,
  localparam int GW = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          load_o,
  output logic          busy_o,
  output logic [GW-1:0] grp_o,
  output logic          done_o
);
  logic          busy_q, done_q;
  logic [GW-1:0] grp_q;

  assign load_o = start_i && !busy_q;
  assign busy_o = busy_q;
  assign grp_o  = grp_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      grp_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        busy_q <= 1'b1;
        grp_q  <= GW'(NG - 1);
      end else if (busy_q) begin
        if (grp_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          grp_q <= grp_q - 1'b1;
        end
      end
    end
  end

  // latency watch counter
  logic [GW:0] lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lat_q <= '0;
    else if (load_o)  lat_q <= '0;
    else if (busy_q)  lat_q <= lat_q + 1'b1;
  end

  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (32'(lat_q) == NG)) else $error("done latency"); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q) else $error("done width"); // R4
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && grp_q != '0) |=> (busy_q && grp_q == $past(grp_q) - 1'b1)) else $error("start in busy"); // R5
  AST_GRP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (32'(grp_q) < NG)) else $error("group range"); // R7
endmodule

// File: rtl/gf3m_digit_mul.sv
module gf3m_digit_mul import gf3_pkg::*; #(
  parameter int M         = 97,
  parameter int D         = 4,
  parameter int TRI_K     = 16,
  parameter int TRI_MID   = 1,
  parameter int TRI_CONST = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [2*M-1:0] a_i,
  input  logic [2*M-1:0] b_i,
  output logic         done_o,
  output logic [2*M-1:0] res_o
);
  localparam int NG = (M + D - 1) / D;
  localparam int PW = NG * D;
  localparam int GW = (NG > 1) ? $clog2(NG) : 1;

  logic          load, busy;
  logic [GW-1:0] grp;
  logic [2*M-1:0]  a_q, acc_q, acc_nx;
  logic [2*PW-1:0] b_q, b_pad;
  logic [2*D-1:0]  bgrp;

  gf3m_seq_ctrl #(.NG(NG)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .load_o(load), .busy_o(busy), .grp_o(grp), .done_o(done_o)
  );

  always_comb begin
    b_pad = '0;
    b_pad[2*M-1:0] = b_i;
  end

  assign bgrp = b_q[32'(grp) * (2*D) +: 2*D];

  gf3m_step #(.M(M), .D(D), .K(TRI_K), .MID(TRI_MID), .CST(TRI_CONST)) u_step (
    .acc_i(acc_q), .a_i(a_q), .bgrp_i(bgrp), .acc_o(acc_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      acc_q <= '0;
    end else if (load) begin
      a_q   <= a_i;
      b_q   <= b_pad;
      acc_q <= '0;
    end else if (busy) begin
      acc_q <= acc_nx;
    end
  end

  assign res_o = acc_q;

  logic [M-1:0] bad_v;
  for (genvar i = 0; i < M; i++) begin : g_bad
    assign bad_v[i] = &res_o[2*i +: 2];
  end

  AST_NO_BAD_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|bad_v)) else $error("illegal digit code"); // R1
  AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !start_i) |=> $stable(res_o)) else $error("result moved"); // R6
  AST_OPND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> ($stable(a_q) && $stable(b_q))) else $error("operand moved"); // R5
endmodule

// File: tb/gf3m_digit_mul_tb_top.sv
module gf3m_digit_mul_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int M = 7;
  localparam int K = 2;
  localparam int MID = 1;
  localparam int CST = 2;
  localparam int D_FAST = 3;
  localparam int NG_FAST = (M + D_FAST - 1) / D_FAST;
  localparam int NG_SER = M;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2*M-1:0] a = '0, b = '0;
  logic done_f, done_s;
  logic [2*M-1:0] res_f, res_s;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gf3m_digit_mul #(.M(M), .D(D_FAST), .TRI_K(K), .TRI_MID(MID), .TRI_CONST(CST)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .a_i(a), .b_i(b),
    .done_o(done_f), .res_o(res_f)
  );

  gf3m_digit_mul #(.M(M), .D(1), .TRI_K(K), .TRI_MID(MID), .TRI_CONST(CST)) dut_ser_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .a_i(a), .b_i(b),
    .done_o(done_s), .res_o(res_s)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // schoolbook product mod 3, then long division by the trinomial
  function automatic logic [2*M-1:0] ref_mul(input logic [2*M-1:0] x, input logic [2*M-1:0] y);
    int p [2*M-1];
    logic [2*M-1:0] r;
    for (int i = 0; i < 2*M-1; i++) p[i] = 0;
    for (int i = 0; i < M; i++)
      for (int j = 0; j < M; j++)
        p[i+j] = (p[i+j] + int'(x[2*i +: 2]) * int'(y[2*j +: 2])) % 3;
    for (int d = 2*M-2; d >= M; d--) begin
      int c;
      c = p[d];
      p[d] = 0;
      p[d-M+K] = (p[d-M+K] + 3*3 - c*MID) % 3;
      p[d-M]   = (p[d-M] + 3*3 - c*CST) % 3;
    end
    r = '0;
    for (int i = 0; i < M; i++) r[2*i +: 2] = 2'(p[i]);
    return r;
  endfunction

  function automatic logic [2*M-1:0] rnd_elem();
    logic [2*M-1:0] v;
    for (int i = 0; i < M; i++) v[2*i +: 2] = 2'($urandom % 3);
    return v;
  endfunction

  function automatic bit has_bad(input logic [2*M-1:0] v);
    for (int i = 0; i < M; i++) if (v[2*i +: 2] == 2'b11) return 1'b1;
    return 1'b0;
  endfunction

  // one product on both instances; optional extra start while busy
  task automatic run_pair(input logic [2*M-1:0] xa, input logic [2*M-1:0] xb,
                          input bit inject, input string tag);
    logic [2*M-1:0] exp;
    int lat_f, lat_s, pul_f, pul_s;
    logic [2*M-1:0] got_f, got_s;
    exp = ref_mul(xa, xb);
    lat_f = 0; lat_s = 0; pul_f = 0; pul_s = 0;
    got_f = '0; got_s = '0;
    @(negedge clk);
    a = xa; b = xb; start = 1'b1;
    for (int c = 1; c <= 12; c++) begin
      @(negedge clk);
      if (done_f) begin pul_f++; lat_f = c; got_f = res_f; end
      if (done_s) begin pul_s++; lat_s = c; got_s = res_s; end
      if (c == 1) start = 1'b0;
      if (inject && c == 2) begin a = rnd_elem(); b = rnd_elem(); start = 1'b1; end
      if (inject && c == 3) start = 1'b0;
    end
    chk(got_f == exp, "R2/R7", {tag, " product D=3"}, 32'(got_f), 32'(exp));
    chk(got_s == exp, "R2/R8", {tag, " product D=1"}, 32'(got_s), 32'(exp));
    chk(lat_f == NG_FAST + 1, "R3", {tag, " latency D=3"}, lat_f, NG_FAST + 1);
    chk(lat_s == NG_SER + 1, "R8", {tag, " latency D=1"}, lat_s, NG_SER + 1);
    chk(pul_f == 1 && pul_s == 1, "R4", {tag, " done pulses"}, pul_f * 16 + pul_s, 32'h11);
    chk(res_f == exp && res_s == exp, "R6", {tag, " hold"}, 32'(res_f), 32'(exp));
    chk(!has_bad(res_f) && !has_bad(res_s), "R1", {tag, " code 11"}, 32'(res_f), 32'(exp));
    if (inject) chk(got_f == exp && lat_f == NG_FAST + 1, "R5", {tag, " busy start"},
                    32'(got_f), 32'(exp));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!done_f && !done_s, "R9", "done in reset", {done_f, done_s}, 0);
    chk(res_f == '0 && res_s == '0, "R9", "res in reset", 32'(res_f), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done_f && res_f == '0, "R9", "after release", 32'(res_f), 0);
  endtask

  task automatic t_identity();
    logic [2*M-1:0] one;
    one = '0; one[1:0] = 2'd1;
    run_pair(14'h2169, one, 1'b0, "identity");
  endtask

  task automatic t_zero();
    run_pair(rnd_elem(), '0, 1'b0, "zero");
  endtask

  task automatic t_wrap();
    logic [2*M-1:0] xa, xb, exp_w;
    xa = '0; xa[3:2] = 2'd1;            // x
    xb = '0; xb[2*M-1 -: 2] = 2'd1;     // x^(M-1)
    // x^M = -(x^2 + 2) = 2x^2 + 1
    exp_w = '0; exp_w[1:0] = 2'd1; exp_w[5:4] = 2'd2;
    chk(ref_mul(xa, xb) == exp_w, "R2", "model wrap", 32'(ref_mul(xa, xb)), 32'(exp_w));
    run_pair(xa, xb, 1'b0, "wrap");
  endtask

  task automatic t_all_twos();
    logic [2*M-1:0] tw;
    for (int i = 0; i < M; i++) tw[2*i +: 2] = 2'd2;
    run_pair(tw, tw, 1'b0, "all twos");
  endtask

  task automatic t_random();
    for (int n = 0; n < 24; n++) run_pair(rnd_elem(), rnd_elem(), 1'b0, "random");
  endtask

  task automatic t_busy_start();
    for (int n = 0; n < 4; n++) run_pair(rnd_elem(), rnd_elem(), 1'b1, "busy start");
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_identity();
    t_zero();
    t_wrap();
    t_all_twos();
    t_random();
    t_busy_start();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule